// File: doc/BRIEF.md
# Status Byte and Service Request Logic

This block builds an instrument's eight-bit status byte from five summary condition inputs and drives the shared request line of a general-purpose instrument bus. A software-written enable mask selects which conditions may raise the request. The OR of the enabled conditions forms the master summary bit. The request bit, and the line that copies it, is held in a register of its own, separate from the master summary.

The request bit sets when the master summary rises. It clears on a serial poll, on a clear-status command, or when the master summary falls. Once it has been cleared, it sets again only after the master summary has fallen and risen again. A serial poll or a status-byte query loads a copy of the status byte into a reply register. The serial poll puts the request bit in bit 6 of the reply, and the query puts the master summary there.

Top module: `stb_srq`

## Requirements
- R1: The status byte places the instrument-summary input in bit 0, the control-request input in bit 1, the error-available input in bit 2, the message-available input in bit 4 and the event-summary input in bit 5. Bit 6 carries the request or summary bit, and bits 3 and 7 are always 0.
- R2: The master summary is 1 exactly when at least one condition bit and its matching mask bit are both 1. A mask bit of 0 blocks its condition.
- R3: A write loads the mask on the next clock edge. Bit 6 of the mask cannot be written and always reads 0.
- R4: While `por` is high, the mask, the request line, the reply register and the reply strobe are all cleared.
- R5: The request line goes to 1 in the cycle after the master summary rises from 0 to 1, unless a clear arrives in the same cycle. It then stays at 1 until one of the clearing events below occurs.
- R6: A serial poll clears the request line on the next edge. The line stays 0 while the master summary stays 1.
- R7: A clear-status command clears the request line on the next edge. The line stays 0 while the master summary stays 1.
- R8: If the master summary is 0 in a cycle, the request line is 0 in the following cycle.
- R9: After a serial poll, `stb_vld_o` pulses for one cycle in the following cycle. In that cycle `stb_o` holds the status byte sampled in the poll cycle, with the request bit from before the poll in bit 6.
- R10: After a status-byte query, `stb_o` holds the status byte with the master summary in bit 6, and `stb_vld_o` pulses. A query does not clear the request line.
- R11: When a clear and a rise of the master summary fall in the same cycle, the clear wins. When a poll and a query fall in the same cycle, the reply is the poll's.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| ctl_req | input | 1 | Control-request condition |
| evt_sum | input | 1 | Event-summary condition from the event status block |
| msg_avail | input | 1 | Message-available condition |
| err_avail | input | 1 | Error-available condition |
| inst_sum | input | 1 | Instrument-summary condition |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask write data |
| mask_o | output | 8 | Current mask |
| poll_i | input | 1 | Serial-poll pulse |
| query_i | input | 1 | Status-byte query pulse |
| clr_i | input | 1 | Clear-status command pulse |
| stb_o | output | 8 | Status byte reply |
| stb_vld_o | output | 1 | Reply valid, one cycle |
| srq_o | output | 1 | Service request line, active high |

## Verification
Two kinds of event can land on the same edge. A rise of the master summary can coincide with a serial poll or clear-status pulse, and a poll can coincide with a query. Both cases are set up directly: the bench raises an enabled condition in the same cycle as the poll or clear, and it pulses poll and query together. The expected result is that the request line stays 0, that it does not set later while the summary stays 1, and that the reply carries the pre-poll request bit. Random stimulus then mixes these pulses with mask writes and condition changes, and every cycle is compared against a bench model.

// File: rtl/stb_srq.sv
module stb_srq #(
  parameter int W = 8,
  parameter int REQ_BIT = 6
) (
  input  logic         clk,
  input  logic         por,
  input  logic         ctl_req,
  input  logic         evt_sum,
  input  logic         msg_avail,
  input  logic         err_avail,
  input  logic         inst_sum,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] mask_o,
  input  logic         poll_i,
  input  logic         query_i,
  input  logic         clr_i,
  output logic [W-1:0] stb_o,
  output logic         stb_vld_o,
  output logic         srq_o
);
  localparam logic [W-1:0] FIXED0 = W'(1) << REQ_BIT;

  logic [W-1:0] sbits;
  logic         mss, mss_q, rqs;

  assign sbits = {1'b0, 1'b0, evt_sum, msg_avail, 1'b0, err_avail, ctl_req, inst_sum};
  assign mss   = |(sbits & mask_o);
  assign srq_o = rqs;

  always_ff @(posedge clk) begin
    if (por) begin
      mask_o    <= '0;
      mss_q     <= 1'b0;
      rqs       <= 1'b0;
      stb_o     <= '0;
      stb_vld_o <= 1'b0;
    end else begin
      if (wr_en) mask_o <= wr_data & ~FIXED0;
      mss_q <= mss;
      if (poll_i || clr_i || !mss) rqs <= 1'b0;
      else if (!mss_q)             rqs <= 1'b1;
      stb_vld_o <= poll_i || query_i;
      if (poll_i)       stb_o <= sbits | (rqs ? FIXED0 : '0);
      else if (query_i) stb_o <= sbits | (mss ? FIXED0 : '0);
    end
  end
endmodule

// File: rtl/stb_srq_chk.sv
module stb_srq_chk (
  input logic       clk,
  input logic       por,
  input logic       poll_i,
  input logic       clr_i,
  input logic       mss,
  input logic       srq_o,
  input logic       stb_vld_o,
  input logic [7:0] stb_o,
  input logic [7:0] mask_o
);
  a_r3_bit6_zero: assert property (@(posedge clk) disable iff (por) mask_o[6] == 1'b0);
  a_r4_reset_state: assert property (@(posedge clk) disable iff (por)
    $fell(por) |-> (mask_o == 8'h00 && !srq_o && !stb_vld_o));
  a_r5_rise_needs_mss: assert property (@(posedge clk) disable iff (por)
    $rose(srq_o) |-> ($past(mss) && !$past(poll_i) && !$past(clr_i)));
  a_r7_clear_drops_line: assert property (@(posedge clk) disable iff (por)
    (poll_i || clr_i) |=> !srq_o);
  a_r8_fall_drops_line: assert property (@(posedge clk) disable iff (por)
    !mss |=> !srq_o);
  a_r9_poll_reply: assert property (@(posedge clk) disable iff (por)
    poll_i |=> (stb_vld_o && stb_o[6] == $past(srq_o)));
  a_r1_fixed_zero: assert property (@(posedge clk) disable iff (por)
    stb_vld_o |-> (stb_o[7] == 1'b0 && stb_o[3] == 1'b0));
endmodule

bind stb_srq stb_srq_chk u_chk (
  .clk(clk), .por(por), .poll_i(poll_i), .clr_i(clr_i), .mss(mss),
  .srq_o(srq_o), .stb_vld_o(stb_vld_o), .stb_o(stb_o), .mask_o(mask_o)
);

// File: tb/stb_srq_tb.sv
module stb_srq_tb;
  logic clk = 1'b0, por = 1'b1;
  logic ctl_req = 0, evt_sum = 0, msg_avail = 0, err_avail = 0, inst_sum = 0;
  logic wr_en = 0, poll_i = 0, query_i = 0, clr_i = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] mask_o, stb_o;
  logic stb_vld_o, srq_o;
  int checks = 0, errors = 0;

  logic [7:0] emask = '0;
  logic emss_q = 0, erqs = 0;

  always #4 clk = ~clk;

  stb_srq u_dut (.*);

  // c = {ctl, evt, msg, err, inst}
  function automatic logic [7:0] sb(input logic [4:0] c);
    return {2'b00, c[3], c[2], 1'b0, c[1], c[4], c[0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); por = 1;
    @(posedge clk); @(negedge clk);
    emask = '0; emss_q = 0; erqs = 0;
    chk("R4 mask", mask_o, 8'h00);
    chk("R4 srq", {7'b0, srq_o}, 8'h00);
    chk("R4 stb", stb_o, 8'h00);
    chk("R4 vld", {7'b0, stb_vld_o}, 8'h00);
    por = 0;
  endtask

  task automatic step(input logic [4:0] c, input logic w, input logic [7:0] wd,
                      input logic p, input logic q, input logic cl);
    logic [7:0] s, estb;
    logic emss, nrqs;
    {ctl_req, evt_sum, msg_avail, err_avail, inst_sum} = c;
    wr_en = w; wr_data = wd; poll_i = p; query_i = q; clr_i = cl;
    s = sb(c);
    emss = |(s & emask);
    nrqs = (p || cl || !emss) ? 1'b0 : (!emss_q ? 1'b1 : erqs);
    estb = p ? (s | {1'b0, erqs, 6'b0}) : (s | {1'b0, emss, 6'b0});
    @(posedge clk);
    if (w) emask = wd & 8'hBF;
    emss_q = emss; erqs = nrqs;
    @(negedge clk);
    wr_en = 0; poll_i = 0; query_i = 0; clr_i = 0;
    chk("R5/R6/R7/R8/R11 srq", {7'b0, srq_o}, {7'b0, erqs});
    chk("R3 mask", mask_o, emask);
    if (p || q) begin
      chk("R9/R10 vld", {7'b0, stb_vld_o}, 8'h01);
      chk("R1/R9/R10/R11 stb", stb_o, estb);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R3: bit 6 not writable
    step(5'b0, 1, 8'hFF, 0, 0, 0);
    chk("R3 bit6", {7'b0, mask_o[6]}, 8'h00);
    // R2: masked condition does not request
    step(5'b0, 1, 8'h01, 0, 0, 0);
    step(5'b10000, 0, 0, 0, 0, 0);
    chk("R2 masked", {7'b0, srq_o}, 8'h00);
    // R5: enabled condition raises request
    step(5'b00001, 0, 0, 0, 0, 0);
    chk("R5 set", {7'b0, srq_o}, 8'h01);
    // R10: query returns mss, keeps request
    step(5'b00001, 0, 0, 0, 1, 0);
    chk("R10 keep", {7'b0, srq_o}, 8'h01);
    // R6 / R9: poll clears; stays clear while mss held
    step(5'b00001, 0, 0, 1, 0, 0);
    step(5'b00001, 0, 0, 0, 0, 0);
    chk("R6 no reset", {7'b0, srq_o}, 8'h00);
    // R8 then R5 again
    step(5'b00000, 0, 0, 0, 0, 0);
    step(5'b00001, 0, 0, 0, 0, 0);
    chk("R5 reset", {7'b0, srq_o}, 8'h01);
    // R7: clear-status
    step(5'b00001, 0, 0, 0, 0, 1);
    step(5'b00001, 0, 0, 0, 0, 0);
    chk("R7 no reset", {7'b0, srq_o}, 8'h00);
    // R11: rise together with clear / poll, and poll together with query
    step(5'b00000, 0, 0, 0, 0, 0);
    step(5'b00001, 0, 0, 0, 0, 1);
    step(5'b00001, 0, 0, 0, 0, 0);
    step(5'b00000, 0, 0, 0, 0, 0);
    step(5'b00001, 0, 0, 1, 1, 0);
    step(5'b00001, 0, 0, 0, 0, 0);
    chk("R11 poll wins", {7'b0, srq_o}, 8'h00);
    // R1: full layout via query
    step(5'b00000, 1, 8'hFF, 0, 0, 0);
    step(5'b11111, 0, 0, 0, 1, 0);
    chk("R1 layout", stb_o, 8'h77);
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] c;
      c = 5'($urandom);
      step(c, ($urandom % 8) == 0, 8'($urandom), ($urandom % 6) == 0,
           ($urandom % 6) == 0, ($urandom % 9) == 0);
    end
    do_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule